// File: doc/BRIEF.md
# Sixteen-Bit Barrel Shift and Rotate Unit

This block moves the bits of a 16-bit operand left or right by a variable distance in a single clock. A 3-bit operation code selects one of five operations: left shift, sign-extending right shift, right shift that fills vacated bits with ones, zero-filling right shift, and left rotate. The distance comes from an 8-bit count. All shifts use the low five bits of the count, so a distance of 16 to 31 pushes every original bit out. The rotate uses only the low four bits of the count.

A caller presents the operand, count and operation code together with a one-cycle `start` strobe. On the next rising clock edge the result register loads and `done` is high for exactly that one cycle. The result then holds until the next strobe. Operation codes 5, 6 and 7 are not assigned; they load the operand unchanged. The unit produces no condition flags.

Top module: `bsu_top`

## Requirements
- R1: While reset is active, and after it is released with no strobe, `result` is 0 and `done` is 0.
- R2: A high `start` at a rising edge loads `result` at that edge, and `done` is 1 for exactly the following cycle. With `start` low, `done` is 0.
- R3: With `start` low, `result` keeps its value, whatever `operand`, `count` and `opcode` do.
- R4: Opcode 0 (left shift) gives `(operand << (count & 31)) & 16'hFFFF`. Any masked distance from 16 to 31 gives 0, and count bits 7..5 have no effect.
- R5: Opcode 1 (arithmetic right shift) treats `operand` as signed and shifts it right by `count & 31`. Any masked distance from 15 to 31 gives 16 copies of bit 15.
- R6: Opcode 2 (ones-fill right shift) gives `~((~operand) >> (count & 31))`. Vacated upper bits are 1, and masked distances from 16 to 31 give 16'hFFFF.
- R7: Opcode 3 (logical right shift) gives `operand >> (count & 31)` with zero fill. Masked distances from 16 to 31 give 0.
- R8: Opcode 4 (left rotate) takes n = `count & 15` and gives `((operand << n) | (operand >> (16 - n))) & 16'hFFFF`. When n is 0, which includes counts 16, 32 and so on, the result is the operand unchanged.
- R9: Opcodes 5, 6 and 7 load `operand` unchanged into `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released on the clock |
| start | input | 1 | One-cycle strobe that requests an operation |
| opcode | input | 3 | Selects the operation: 0 left shift, 1 arithmetic right shift, 2 ones-fill right shift, 3 logical right shift, 4 left rotate, 5 to 7 pass-through |
| operand | input | 16 | Value to be shifted or rotated |
| count | input | 8 | Shift distance; low five bits used for shifts, low four bits for the rotate |
| result | output | 16 | Registered result |
| done | output | 1 | High for one cycle after each strobe |

## Verification
The bench drives all eight opcodes with all 256 counts over several operand patterns. The patterns include sign-set, sign-clear, all-ones and alternating values. This catches a design that masks the rotate distance to five bits: a count of 16 would then clear the word instead of returning it. It also catches a design that lets count bits 7..5 through, which corrupts counts such as 32 or 200 that should act like small ones. Distances of 16 to 31 are checked so that a shifter built for 0..15 only, which wraps instead of flushing, gives wrong zero, sign or ones fill. Idle cycles with changing inputs expose a result register that loads without a strobe or a `done` that stays high.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  localparam int unsigned BSU_OP_W = 3;

  typedef enum logic [BSU_OP_W-1:0] {
    BSU_SHL    = 3'd0,
    BSU_ASR    = 3'd1,
    BSU_SRONES = 3'd2,
    BSU_LSR    = 3'd3,
    BSU_ROL    = 3'd4
  } bsu_op_e;

endpackage

// File: rtl/bsu_rst_sync.sv
module bsu_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;

endmodule

// File: rtl/bsu_rshift.sv
// Log-stage right shifter with a selectable fill bit.
// Stages whose step reaches the word width flush the whole word.
module bsu_rshift #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 5
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          fill,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stg [AW+1];

  assign stg[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    if (STEP >= W) begin : g_flush
      assign stg[k+1] = amt[k] ? {W{fill}} : stg[k];
    end else begin : g_part
      assign stg[k+1] = amt[k] ? {{STEP{fill}}, stg[k][W-1:STEP]} : stg[k];
    end
  end

  assign dout = stg[AW];

endmodule

// File: rtl/bsu_rotl.sv
// Log-stage left rotator; W must be a power of two and RW = log2(W).
module bsu_rotl #(
  parameter int unsigned W  = 16,
  parameter int unsigned RW = 4
) (
  input  logic [W-1:0]  din,
  input  logic [RW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stg [RW+1];

  assign stg[0] = din;

  for (genvar k = 0; k < RW; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign stg[k+1] = amt[k] ? {stg[k][W-1-STEP:0], stg[k][W-1:W-STEP]} : stg[k];
  end

  assign dout = stg[RW];

endmodule

// File: rtl/bsu_top.sv
module bsu_top #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [bsu_pkg::BSU_OP_W-1:0]  opcode,
  input  logic [DATA_W-1:0]             operand,
  input  logic [CNT_W-1:0]              count,
  output logic [DATA_W-1:0]             result,
  output logic                          done
);

  import bsu_pkg::*;

  localparam int unsigned ROT_W = $clog2(DATA_W);
  localparam int unsigned SH_W  = ROT_W + 1;

  logic rst_q_n;

  bsu_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q_n)
  );

  // Bit reversal lets one right shifter also serve the left shift.
  logic [DATA_W-1:0] opnd_rev;
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_in
    assign opnd_rev[i] = operand[DATA_W-1-i];
  end

  bsu_op_e           op;
  logic              is_shl;
  logic              sh_fill;
  logic [DATA_W-1:0] sh_in;
  logic [DATA_W-1:0] sh_out;
  logic [DATA_W-1:0] sh_out_rev;
  logic [DATA_W-1:0] rot_out;

  assign op     = bsu_op_e'(opcode);
  assign is_shl = (op == BSU_SHL);
  assign sh_in  = is_shl ? opnd_rev : operand;

  always_comb begin
    case (op)
      BSU_ASR:    sh_fill = operand[DATA_W-1];
      BSU_SRONES: sh_fill = 1'b1;
      default:    sh_fill = 1'b0;
    endcase
  end

  bsu_rshift #(.W(DATA_W), .AW(SH_W)) u_shift (
    .din  (sh_in),
    .amt  (count[SH_W-1:0]),
    .fill (sh_fill),
    .dout (sh_out)
  );

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_out
    assign sh_out_rev[i] = sh_out[DATA_W-1-i];
  end

  bsu_rotl #(.W(DATA_W), .RW(ROT_W)) u_rot (
    .din  (operand),
    .amt  (count[ROT_W-1:0]),
    .dout (rot_out)
  );

  logic [DATA_W-1:0] op_res;
  always_comb begin
    case (op)
      BSU_SHL:    op_res = sh_out_rev;
      BSU_ASR,
      BSU_SRONES,
      BSU_LSR:    op_res = sh_out;
      BSU_ROL:    op_res = rot_out;
      default:    op_res = operand;
    endcase
  end

  // Next-state
  logic [DATA_W-1:0] res_d, res_q;
  logic              done_d, done_q;

  always_comb begin
    res_d  = res_q;
    done_d = start;
    if (start) begin
      res_d = op_res;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      done_q <= done_d;
    end
  end

  assign result = res_q;
  assign done   = done_q;

  p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    start |=> done);
  p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !start |=> !done);
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !start |=> $stable(result));
  p_shl_flush_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start && opcode == 3'd0 && count[ROT_W]) |=> (result == '0));
  p_asr_flush_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start && opcode == 3'd1 && count[ROT_W]) |=> (result == {DATA_W{$past(operand[DATA_W-1])}}));
  p_rol_zero_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start && opcode == 3'd4 && count[ROT_W-1:0] == '0) |=> (result == $past(operand)));
  p_passthru_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start && opcode > 3'd4) |=> (result == $past(operand)));

endmodule

// File: tb/bsu_top_test.sv
module bsu_top_test;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [2:0]  opcode;
  logic [15:0] operand;
  logic [7:0]  count;
  logic [15:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;

  bsu_top uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .opcode  (opcode),
    .operand (operand),
    .count   (count),
    .result  (result),
    .done    (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] model(input logic [2:0] o, input logic [15:0] v, input logic [7:0] c);
    int n;
    int s;
    logic [31:0] w;
    n = int'(c & 8'd31);
    case (o)
      3'd0: begin w = {16'h0, v} << n; return w[15:0]; end
      3'd1: begin s = int'(signed'(v)); s = s >>> n; return 16'(s); end
      3'd2: begin w = {16'h0, ~v} >> n; return ~w[15:0]; end
      3'd3: begin w = {16'h0, v} >> n; return w[15:0]; end
      3'd4: begin
        n = int'(c & 8'd15);
        w = ({16'h0, v} << n) | ({16'h0, v} >> (16 - n));
        return w[15:0];
      end
      default: return v;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [15:0] pats [6];
  logic [15:0] held;

  initial begin
    pats[0] = 16'h8001; pats[1] = 16'h7FFE; pats[2] = 16'hFFFF;
    pats[3] = 16'hA5C3; pats[4] = 16'h1234; pats[5] = 16'h0000;
    rst_n = 1'b0; start = 1'b0; opcode = 3'd0; operand = 16'hBEEF; count = 8'd3;
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 16'h0);
    check("R1 reset done", {15'h0, done}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 released result", result, 16'h0);
    check("R1 released done", {15'h0, done}, 16'h0);

    // Full sweep, back-to-back strobes (R2, R4..R9)
    for (int p = 0; p < 6; p++) begin
      for (int o = 0; o < 8; o++) begin
        for (int c = 0; c < 256; c++) begin
          start = 1'b1; opcode = 3'(o); operand = pats[p]; count = 8'(c);
          @(negedge clk);
          check("R2 done", {15'h0, done}, 16'h1);
          check(tag(3'(o)), result, model(3'(o), pats[p], 8'(c)));
        end
      end
    end

    // Idle: result holds, done low (R2, R3)
    start = 1'b0;
    @(negedge clk);
    held = result;
    for (int i = 0; i < 20; i++) begin
      opcode = 3'(i); operand = 16'(i * 16'h1357); count = 8'(i * 11);
      @(negedge clk);
      check("R2 done idle", {15'h0, done}, 16'h0);
      check("R3 hold", result, held);
    end

    // Single strobe then idle: exactly one done pulse (R2)
    start = 1'b1; opcode = 3'd4; operand = 16'h8001; count = 8'd16;
    @(negedge clk);
    start = 1'b0; operand = 16'h0F0F;
    check("R2 pulse", {15'h0, done}, 16'h1);
    check("R8 count16", result, 16'h8001);
    @(negedge clk);
    check("R2 pulse end", {15'h0, done}, 16'h0);
    check("R3 hold after", result, 16'h8001);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule